// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address sequence for a short memory burst. Either of two load strobes, one driven from the processor side and one from the memory controller side, captures an external address as the base of a new burst. The upper address bits are then frozen, while the low `BEAT_W` bits step through `2**BEAT_W` beats each time the advance input is asserted. With the default `BEAT_W = 2`, a burst has four beats.

The step order is selected when the burst is loaded. It is either a linear count that wraps within the burst window, or an interleaved order that XORs the base low bits with a beat counter. Interleaved order is encoded as 0 on the order input, so an order input tied low gives interleaved bursts.

A parameter can also fix the order at build time, and the order input is then ignored. Bursts do not have to be used. A fresh load on every cycle makes the block follow the external address with one cycle of latency.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, before any load, `addr_o` is zero.
- R2: A cycle with `cpu_ld_i` high, `ctl_ld_i` high, or both, makes `addr_o` equal to that cycle's `addr_i` from the next clock edge.
- R3: When a load strobe and `adv_i` are both high in the same cycle, the load wins and the output is the new base, not an advanced address.
- R4: `adv_i` high with no strobe moves the output to the next beat. With no strobe and no advance, `addr_o` holds its value.
- R5: With `order_i` = 1 (linear) at load time, the low two bits advance by one modulo 4 per step, for example 2, 3, 0, 1.
- R6: With `order_i` = 0 (interleaved, the tied-low default) at load time, the low two bits equal the loaded low bits XOR a 2-bit beat counter that starts at 0, for example 1, 0, 3, 2.
- R7: After the fourth beat, a further advance returns the low bits to the loaded starting value, in both orders.
- R8: Bits above the low two never change unless a strobe loads a new address.
- R9: A strobe on every consecutive cycle restarts the burst each time, so `addr_o` follows `addr_i` one cycle late.
- R10: `order_i` is sampled only on a load. Changing it in the middle of a burst does not alter that burst's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ld_i | input | 1 | Processor-side load strobe |
| ctl_ld_i | input | 1 | Controller-side load strobe |
| adv_i | input | 1 | Advance to the next beat |
| order_i | input | 1 | Order at load: 1 linear, 0 interleaved |
| addr_i | input | ADDR_W | External base address |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench starts bursts from odd and even low bits in both orders. It runs each burst past the fourth beat, so that a design which carries into the upper bits, or fails to wrap back to the start, shows the wrong address. It drives a strobe and an advance in the same cycle to catch a design that steps off the new base. It fires both strobes together and each strobe alone to expose a load path that honours only one of them. It toggles the order input mid-burst to catch a design that reads the order live instead of latching it, and it loads back to back to catch a design that needs an idle cycle between loads.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic {
      ORD_XOR = 1'b0,
      ORD_LIN = 1'b1
   } order_e;

   localparam int ORDER_RUNTIME   = 0;
   localparam int ORDER_FIXED_LIN = 1;
   localparam int ORDER_FIXED_XOR = 2;
endpackage

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2,
   localparam int HI_W  = ADDR_W - BEAT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  bag_pkg::order_e     order_i,
   output logic [HI_W-1:0]     base_hi_o,
   output logic [BEAT_W-1:0]   base_lo_o,
   output bag_pkg::order_e     order_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_hi_o <= '0;
         base_lo_o <= '0;
         order_o   <= bag_pkg::ORD_XOR;
      end else if (load_i) begin
         base_hi_o <= addr_i[ADDR_W-1:BEAT_W];
         base_lo_o <= addr_i[BEAT_W-1:0];
         order_o   <= order_i;
      end
   end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              step_i,
   output logic [BEAT_W-1:0] beat_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      beat_o <= '0;
      else if (clr_i)  beat_o <= '0;
      else if (step_i) beat_o <= beat_o + 1'b1;
   end
endmodule

// File: rtl/bag_seq_map.sv
module bag_seq_map #(
   parameter int BEAT_W     = 2,
   parameter int ORDER_MODE = bag_pkg::ORDER_RUNTIME
) (
   input  logic [BEAT_W-1:0] base_lo_i,
   input  logic [BEAT_W-1:0] beat_i,
   input  bag_pkg::order_e   order_i,
   output logic [BEAT_W-1:0] lo_o
);
   logic [BEAT_W-1:0] lin_lo;
   logic [BEAT_W-1:0] xor_lo;

   assign lin_lo = base_lo_i + beat_i;
   assign xor_lo = base_lo_i ^ beat_i;

   generate
      if (ORDER_MODE == bag_pkg::ORDER_FIXED_LIN) begin : g_lin
         logic unused_ord;
         assign unused_ord = order_i;
         assign lo_o = lin_lo;
      end else if (ORDER_MODE == bag_pkg::ORDER_FIXED_XOR) begin : g_xor
         logic unused_ord;
         assign unused_ord = order_i;
         assign lo_o = xor_lo;
      end else begin : g_rt
         assign lo_o = (order_i == bag_pkg::ORD_LIN) ? lin_lo : xor_lo;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int ADDR_W     = 20,
   parameter int BEAT_W     = 2,
   parameter int ORDER_MODE = bag_pkg::ORDER_RUNTIME
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_ld_i,
   input  logic              ctl_ld_i,
   input  logic              adv_i,
   input  logic              order_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int HI_W = ADDR_W - BEAT_W;

   generate
      if (BEAT_W < 1) begin : g_bad_beat
         $error("burst_addr_gen: BEAT_W must be at least 1");
      end
      if (ADDR_W <= BEAT_W) begin : g_bad_addr
         $error("burst_addr_gen: ADDR_W must exceed BEAT_W");
      end
      if (ORDER_MODE < 0 || ORDER_MODE > 2) begin : g_bad_mode
         $error("burst_addr_gen: ORDER_MODE out of range");
      end
   endgenerate

   logic              load;
   logic              step;
   logic [HI_W-1:0]   base_hi;
   logic [BEAT_W-1:0] base_lo;
   logic [BEAT_W-1:0] beat;
   logic [BEAT_W-1:0] lo;
   bag_pkg::order_e   ord_in;
   bag_pkg::order_e   ord_q;

   assign load   = cpu_ld_i | ctl_ld_i;
   assign step   = adv_i & ~load;
   assign ord_in = bag_pkg::order_e'(order_i);

   bag_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .addr_i    (addr_i),
      .order_i   (ord_in),
      .base_hi_o (base_hi),
      .base_lo_o (base_lo),
      .order_o   (ord_q)
   );

   bag_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (load),
      .step_i (step),
      .beat_o (beat)
   );

   bag_seq_map #(.BEAT_W(BEAT_W), .ORDER_MODE(ORDER_MODE)) u_map (
      .base_lo_i (base_lo),
      .beat_i    (beat),
      .order_i   (ord_q),
      .lo_o      (lo)
   );

   assign addr_o = {base_hi, lo};
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
   parameter int ADDR_W     = 20,
   parameter int BEAT_W     = 2,
   parameter int ORDER_MODE = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ld_i,
   input logic              ctl_ld_i,
   input logic              adv_i,
   input logic              order_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [ADDR_W-1:0] addr_o
);
   logic              ld;
   logic              eff_lin;
   logic              ck_lin;
   logic [BEAT_W-1:0] ck_base_lo;
   logic [BEAT_W-1:0] ck_cnt;

   assign ld      = cpu_ld_i | ctl_ld_i;
   assign eff_lin = (ORDER_MODE == 1) ? 1'b1 : (ORDER_MODE == 2) ? 1'b0 : order_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ck_lin     <= 1'b0;
         ck_base_lo <= '0;
         ck_cnt     <= '0;
      end else if (ld) begin
         ck_lin     <= eff_lin;
         ck_base_lo <= addr_i[BEAT_W-1:0];
         ck_cnt     <= '0;
      end else if (adv_i) begin
         ck_cnt     <= ck_cnt + 1'b1;
      end
   end

   // R1
   always @(negedge clk) begin
      if (!rst_n) reset_zero_chk: assert (addr_o == '0);
   end

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> addr_o == $past(addr_i));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !adv_i) |=> $stable(addr_o));

   // R8
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

   // R5
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv_i && ck_lin) |=>
         addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1));

   // R6
   xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv_i && !ck_lin) |=>
         addr_o[BEAT_W-1:0] == (ck_base_lo ^ ck_cnt));

   // R7
   wrap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv_i && ck_cnt == {BEAT_W{1'b1}}) |=>
         addr_o[BEAT_W-1:0] == ck_base_lo);
endmodule

bind burst_addr_gen bag_chk #(
   .ADDR_W     (ADDR_W),
   .BEAT_W     (BEAT_W),
   .ORDER_MODE (ORDER_MODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_ld_i (cpu_ld_i),
   .ctl_ld_i (ctl_ld_i),
   .adv_i    (adv_i),
   .order_i  (order_i),
   .addr_i   (addr_i),
   .addr_o   (addr_o)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
   localparam int AW = 20;

   typedef struct {
      logic [AW-1:0] addr;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_ld = 1'b0;
   logic          ctl_ld = 1'b0;
   logic          adv = 1'b0;
   logic          ord = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;

   int n_cmp = 0;
   int n_bad = 0;
   exp_t sb_q[$];

   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_beat = '0;
   logic          m_lin  = 1'b0;

   always #2 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_ld_i (cpu_ld),
      .ctl_ld_i (ctl_ld),
      .adv_i    (adv),
      .order_i  (ord),
      .addr_i   (addr_in),
      .addr_o   (addr_out)
   );

   function automatic logic [AW-1:0] model_addr();
      logic [1:0] lo;
      lo = m_lin ? (m_base[1:0] + m_beat) : (m_base[1:0] ^ m_beat);
      return {m_base[AW-1:2], lo};
   endfunction

   task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: addr_o=%h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic c, input logic k, input logic a,
                        input logic o, input logic [AW-1:0] ad, input string tag);
      exp_t e;
      @(negedge clk);
      cpu_ld = c; ctl_ld = k; adv = a; ord = o; addr_in = ad;
      if (c || k) begin
         m_base = ad; m_beat = '0; m_lin = o;
      end else if (a) begin
         m_beat = m_beat + 1'b1;
      end
      e.addr = model_addr();
      e.tag  = tag;
      sb_q.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(addr_out, e.addr, e.tag);
         end
      end
   end

   logic done = 1'b0;

   initial begin : watchdog
      #(4ns * 20000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run hung, actual running expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check(addr_out, '0, "R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(addr_out, '0, "R1 after release");

      // R5 / R7: linear from low bits 2, beyond the fourth beat
      drive(1, 0, 0, 1, 20'h12342, "R2 cpu load");
      for (int i = 0; i < 5; i++) drive(0, 0, 1, 1, 20'h00000, "R5 R7 R8 linear step");
      // R4: idle holds
      drive(0, 0, 0, 0, 20'hFFFFF, "R4 hold");
      drive(0, 0, 0, 1, 20'h00003, "R4 hold");

      // R6 / R7: interleaved from low bits 1
      drive(0, 1, 0, 0, 20'hABCD1, "R2 ctl load");
      for (int i = 0; i < 5; i++) drive(0, 0, 1, 0, 20'h55555, "R6 R7 R8 xor step");

      // R6: interleaved from low bits 3, R10 order toggles mid-burst
      drive(1, 0, 0, 0, 20'h0F0F3, "R2 cpu load");
      drive(0, 0, 1, 1, 20'h00000, "R10 order ignored");
      drive(0, 0, 1, 1, 20'h00000, "R10 order ignored");
      drive(0, 0, 1, 0, 20'h00000, "R10 order ignored");

      // R10: linear burst with order dropped to 0 mid-burst
      drive(0, 1, 0, 1, 20'h77771, "R2 ctl load");
      drive(0, 0, 1, 0, 20'h00000, "R10 order ignored");
      drive(0, 0, 1, 0, 20'h00000, "R10 order ignored");

      // R3: strobe and advance together
      drive(0, 0, 1, 1, 20'h00000, "R4 step");
      drive(1, 0, 1, 1, 20'h3C3C2, "R3 load beats adv");
      drive(0, 1, 1, 0, 20'h12345, "R3 load beats adv");

      // R2: both strobes together
      drive(1, 1, 0, 1, 20'hFEDC3, "R2 both strobes");
      drive(0, 0, 1, 1, 20'h00000, "R5 step");

      // R9: back-to-back loads
      for (int i = 0; i < 6; i++)
         drive(i[0], ~i[0], 1, i[1], 20'(32'h1111 * (i + 3)), "R9 back-to-back");
      drive(0, 0, 0, 0, 20'h00000, "R4 hold");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule